// File: doc/BRIEF.md
# AES3 Receiver Status Indicator

This block sits behind the bi-phase decoder and clock-recovery stage of an AES3 / S/PDIF receiver. For every decoded sub-frame the front end presents a one-cycle strobe together with that sub-frame's parity and coding-violation flags, the current PLL lock state, the channel-status bit carried by the sub-frame, a flag saying whether the sub-frame belongs to channel A, and a marker for the sub-frame that opened a new channel-status block.

The block resamples a single receive-error indicator once per sub-frame. From channel A it also gathers the 192-bit channel-status block and keeps only the first two bytes. From those bytes it decodes four registered indicators: professional/consumer, pre-emphasis, copy permission and original-versus-copy generation. The generation indicator depends on the category code, because a configurable set of category groups reads the L bit with inverted sense. All status indicators change only when a complete, lock-clean block has arrived. They hold their values through lock loss.

Top module: `aes_rx_status_ind`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to `rx_err`=1, `pro`=0, `emph_n`=1, `copy_ok`=0 and `orig`=0.
- R2: `rx_err` changes only at an edge where `sf_valid` is high. The other inputs have no effect on it in cycles without a strobe.
- R3: A strobed sub-frame with `par_err`=1 makes `rx_err` 1 after that edge.
- R4: A strobed sub-frame with `bip_err`=1 makes `rx_err` 1 after that edge.
- R5: A strobed sub-frame with `pll_lock`=0 makes `rx_err` 1. It returns to 0 only after a strobed sub-frame that has lock and no parity or coding error.
- R6: Channel-status bits are taken only from strobed sub-frames with `sf_chan_a`=1 and lock. Bit 0 is the one on the channel-A sub-frame with `blk_start`=1. The next 191 channel-A sub-frames carry bits 1 to 191. The status outputs update at the edge of bit 191 and at no other time. Bits on channel-B sub-frames and channel-A sub-frames received outside a block have no effect.
- R7: `pro` equals status bit 0 (1 = professional).
- R8: In consumer mode (bit 0 = 0), `emph_n` is 0 exactly when bits 3, 4, 5 are 1, 0, 0. In professional mode it is 0 exactly when bits 2, 3, 4 are 1, 1, 0. In every other case it is 1.
- R9: In consumer mode `copy_ok` equals bit 2. In professional mode it is 1.
- R10: In consumer mode the category code is bits 8..14, with bit 8 as the LSB, and L is bit 15. `orig` equals L for ordinary categories and equals the inverse of L for inverting categories. In professional mode `orig` is 1.
- R11: A strobed sub-frame on either channel that lacks lock abandons the block being gathered. The status outputs hold their values, and gathering resumes only at the next `blk_start`.
- R12: A channel-A `blk_start` in the middle of a block discards the partial block and restarts at bit 0.
- R13: A category is inverting when it matches an entry of the parameter lists under that entry's mask. The defaults are (code & 0x07) == 0x01 or (code & 0x0F) == 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sf_valid | input | 1 | One-cycle strobe per decoded sub-frame |
| sf_chan_a | input | 1 | Strobed sub-frame belongs to channel A |
| blk_start | input | 1 | Strobed sub-frame opens a channel-status block |
| par_err | input | 1 | Parity failure on the strobed sub-frame |
| bip_err | input | 1 | Bi-phase coding violation on the strobed sub-frame |
| pll_lock | input | 1 | Receive clock recovery is locked |
| cs_bit | input | 1 | Channel-status bit of the strobed sub-frame |
| rx_err | output | 1 | Receive-error indicator, resampled per sub-frame |
| emph_n | output | 1 | Low for 50/15 us pre-emphasis, high otherwise |
| copy_ok | output | 1 | Copy permission |
| orig | output | 1 | 1 = original material, 0 = copy of some generation |
| pro | output | 1 | 1 = professional format |

## Verification
The hardest state to reach is the commit edge itself. It takes 191 correctly strobed, lock-clean channel-A sub-frames after an aligned start, and a single misplaced strobe silently moves the edge or suppresses it. The stimulus drives complete interleaved A/B blocks. The B bits are the inverse of the A bits, and parity and coding errors are injected on B sub-frames. Idle cycles carry noisy error and start inputs. The output is compared every cycle, so an update one sub-frame early or late shows up at once. Dedicated sequences drop lock partway through a block, restart a block before its end, and send channel-A bits with no start marker. In each case the status outputs must hold.

// File: rtl/aes_rxstat_pkg.sv
// Package: shared types and fixed channel-status field positions for the
// receiver status indicator. Bit numbers count in arrival order, bit 0 first.
package aes_rxstat_pkg;

    // Number of leading channel-status bits the decoder needs (bytes 0 and 1)
    localparam int CS_KEEP_BITS = 16;
    localparam int CAT_W        = 7;

    // Field positions inside the kept status word
    localparam int POS_PRO      = 0;
    localparam int POS_COPY     = 2;
    localparam int POS_CON_EMPH = 3;   // consumer emphasis field, 3 bits
    localparam int POS_PRO_EMPH = 2;   // professional emphasis field, 3 bits
    localparam int POS_CAT      = 8;   // category code, 7 bits, LSB first
    localparam int POS_LBIT     = 15;

    // Decoded indicator set
    typedef struct packed {
        logic pro;
        logic emph_n;
        logic copy_ok;
        logic orig;
    } rx_status_t;

    localparam rx_status_t STATUS_DEFAULT = '{pro: 1'b0, emph_n: 1'b1,
                                              copy_ok: 1'b0, orig: 1'b0};

endpackage

// File: rtl/rx_err_tracker.sv
// Module: rx_err_tracker
// Holds the receive-error indicator. The indicator is resampled only on a
// sub-frame strobe, from the parity flag, the coding-violation flag and the
// lock state. Assumes the flags are valid in the strobe cycle.
module rx_err_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sf_valid,
    input  logic par_err,
    input  logic bip_err,
    input  logic pll_lock,
    output logic rx_err
);

    logic err_q;

    // Resample the error indicator once per strobed sub-frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b1;
        end else if (sf_valid) begin
            err_q <= par_err | bip_err | ~pll_lock;
        end
    end

    assign rx_err = err_q;

    assert_err_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_valid |=> $stable(rx_err));
    assert_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && par_err) |=> rx_err);
    assert_biphase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && bip_err) |=> rx_err);
    assert_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && !pll_lock) |=> rx_err);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && pll_lock && !par_err && !bip_err) |=> !rx_err);

endmodule

// File: rtl/cs_block_collector.sv
// Module: cs_block_collector
// Gathers channel-status bits from channel-A sub-frames into an aligned block
// of BLOCK_LEN bits. Only the first CS_KEEP_BITS are stored. A one-cycle
// blk_done marks the strobe that carries the last bit of a lock-clean block.
// Assumes blk_start is meaningful only on a strobed channel-A sub-frame.
module cs_block_collector
    import aes_rxstat_pkg::*;
#(
    parameter int BLOCK_LEN = 192
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sf_valid,
    input  logic                    sf_chan_a,
    input  logic                    blk_start,
    input  logic                    pll_lock,
    input  logic                    cs_bit,
    output logic [CS_KEEP_BITS-1:0] cs_word,
    output logic                    blk_done
);

    localparam int IDX_W  = $clog2(BLOCK_LEN);
    localparam int KEEP_W = $clog2(CS_KEEP_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);
    localparam logic [IDX_W-1:0] KEEP_LIM = IDX_W'(CS_KEEP_BITS);

    logic                    collecting_q;
    logic [IDX_W-1:0]        bit_idx_q;    // index of the next expected bit
    logic [CS_KEEP_BITS-1:0] keep_q;
    logic                    a_take;

    // A channel-A bit that is usable for gathering
    assign a_take   = sf_valid & pll_lock & sf_chan_a;
    assign blk_done = a_take & ~blk_start & collecting_q & (bit_idx_q == LAST_IDX);

    // Block alignment, bit counting and abort on lock loss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collecting_q <= 1'b0;
            bit_idx_q    <= '0;
        end else if (sf_valid && !pll_lock) begin
            collecting_q <= 1'b0;
        end else if (a_take && blk_start) begin
            collecting_q <= 1'b1;
            bit_idx_q    <= IDX_W'(1);
        end else if (a_take && collecting_q) begin
            if (bit_idx_q == LAST_IDX) begin
                collecting_q <= 1'b0;
            end else begin
                bit_idx_q <= bit_idx_q + IDX_W'(1);
            end
        end
    end

    // Store the leading status bits of the current block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else if (a_take && blk_start) begin
            keep_q[0] <= cs_bit;
        end else if (a_take && collecting_q && (bit_idx_q < KEEP_LIM)) begin
            keep_q[bit_idx_q[KEEP_W-1:0]] <= cs_bit;
        end
    end

    assign cs_word = keep_q;

    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        collecting_q |-> (bit_idx_q != '0 && bit_idx_q <= LAST_IDX));
    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (a_take && blk_start) |=> (collecting_q && bit_idx_q == IDX_W'(1)));
    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && !pll_lock) |=> !collecting_q);

endmodule

// File: rtl/cs_field_decoder.sv
// Module: cs_field_decoder
// Combinational decode of the kept status bytes into the indicator set.
// The inverting category groups are matched under per-group masks.
// Assumes cs_word holds bits 0..15 of the block, with bit 0 at index 0.
module cs_field_decoder
    import aes_rxstat_pkg::*;
#(
    parameter int                     N_INV    = 2,
    parameter logic [N_INV*CAT_W-1:0] INV_VAL  = {7'h04, 7'h01},
    parameter logic [N_INV*CAT_W-1:0] INV_MASK = {7'h0F, 7'h07}
) (
    input  logic [CS_KEEP_BITS-1:0] cs_word,
    output rx_status_t              status
);

    logic [CAT_W-1:0] category;
    logic [N_INV-1:0] grp_hit;
    logic             inverting;
    logic             l_bit;
    logic             is_pro;

    assign category = cs_word[POS_CAT +: CAT_W];
    assign l_bit    = cs_word[POS_LBIT];
    assign is_pro   = cs_word[POS_PRO];

    // One comparator per inverting category group
    for (genvar g = 0; g < N_INV; g++) begin : g_inv_grp
        localparam logic [CAT_W-1:0] GV = INV_VAL[g*CAT_W +: CAT_W];
        localparam logic [CAT_W-1:0] GM = INV_MASK[g*CAT_W +: CAT_W];
        assign grp_hit[g] = ((category & GM) == (GV & GM));
    end

    assign inverting = |grp_hit;

    // Mode-dependent field interpretation
    always_comb begin
        status.pro = is_pro;
        if (is_pro) begin
            status.emph_n  = ~(cs_word[POS_PRO_EMPH] & cs_word[POS_PRO_EMPH+1]
                               & ~cs_word[POS_PRO_EMPH+2]);
            status.copy_ok = 1'b1;
            status.orig    = 1'b1;
        end else begin
            status.emph_n  = ~(cs_word[POS_CON_EMPH] & ~cs_word[POS_CON_EMPH+1]
                               & ~cs_word[POS_CON_EMPH+2]);
            status.copy_ok = cs_word[POS_COPY];
            status.orig    = inverting ? ~l_bit : l_bit;
        end
    end

endmodule

// File: rtl/aes_rx_status_ind.sv
// Module: aes_rx_status_ind (top)
// Drives the receive-error indicator and the registered status indicators.
// The status register loads only when the collector reports a complete block.
// Assumes one sf_valid pulse per sub-frame from the decoder front end.
module aes_rx_status_ind
    import aes_rxstat_pkg::*;
#(
    parameter int                     BLOCK_LEN = 192,
    parameter int                     N_INV     = 2,
    parameter logic [N_INV*CAT_W-1:0] INV_VAL   = {7'h04, 7'h01},
    parameter logic [N_INV*CAT_W-1:0] INV_MASK  = {7'h0F, 7'h07}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sf_valid,
    input  logic sf_chan_a,
    input  logic blk_start,
    input  logic par_err,
    input  logic bip_err,
    input  logic pll_lock,
    input  logic cs_bit,
    output logic rx_err,
    output logic emph_n,
    output logic copy_ok,
    output logic orig,
    output logic pro
);

    logic [CS_KEEP_BITS-1:0] cs_word;
    logic                    blk_done;
    rx_status_t              dec_status;
    rx_status_t              status_q;

    rx_err_tracker u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .sf_valid (sf_valid),
        .par_err  (par_err),
        .bip_err  (bip_err),
        .pll_lock (pll_lock),
        .rx_err   (rx_err)
    );

    cs_block_collector #(.BLOCK_LEN(BLOCK_LEN)) u_coll (
        .clk       (clk),
        .rst_n     (rst_n),
        .sf_valid  (sf_valid),
        .sf_chan_a (sf_chan_a),
        .blk_start (blk_start),
        .pll_lock  (pll_lock),
        .cs_bit    (cs_bit),
        .cs_word   (cs_word),
        .blk_done  (blk_done)
    );

    cs_field_decoder #(.N_INV(N_INV), .INV_VAL(INV_VAL), .INV_MASK(INV_MASK)) u_dec (
        .cs_word (cs_word),
        .status  (dec_status)
    );

    // Load the indicator set at the end of each complete block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= STATUS_DEFAULT;
        end else if (blk_done) begin
            status_q <= dec_status;
        end
    end

    assign pro     = status_q.pro;
    assign emph_n  = status_q.emph_n;
    assign copy_ok = status_q.copy_ok;
    assign orig    = status_q.orig;

    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_done |=> $stable(status_q));
    assert_no_commit_unlocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && !pll_lock) |-> !blk_done);
    assert_pro_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pro |-> copy_ok);
    assert_pro_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pro |-> orig);

endmodule

// File: tb/aes_rx_status_ind_tb_top.sv
`timescale 1ns/1ps
module aes_rx_status_ind_tb_top;

    typedef struct {
        logic  err;
        logic  pro;
        logic  emph_n;
        logic  copy_ok;
        logic  orig;
        string etag;
        string stag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n, sf_valid, sf_chan_a, blk_start, par_err, bip_err, pll_lock, cs_bit;
    logic rx_err, emph_n, copy_ok, orig, pro;

    int checks = 0;
    int errors = 0;
    exp_item_t q[$];

    // reference state, written from the requirements
    logic m_err, m_pro, m_emph_n, m_copy, m_orig, m_coll;
    int   m_idx;
    logic [15:0] m_buf;

    always #2 clk = ~clk;

    aes_rx_status_ind dut_i (
        .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan_a(sf_chan_a),
        .blk_start(blk_start), .par_err(par_err), .bip_err(bip_err),
        .pll_lock(pll_lock), .cs_bit(cs_bit), .rx_err(rx_err), .emph_n(emph_n),
        .copy_ok(copy_ok), .orig(orig), .pro(pro)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // commit decode per R7..R10, R13
    task automatic commit(input logic [15:0] b);
        logic [6:0] cat;
        logic inv;
        cat = b[14:8];
        inv = ((cat & 7'h07) == 7'h01) || ((cat & 7'h0F) == 7'h04);
        m_pro = b[0];
        if (b[0]) begin
            m_emph_n = !(b[2] && b[3] && !b[4]);
            m_copy = 1'b1;
            m_orig = 1'b1;
        end else begin
            m_emph_n = !(b[3] && !b[4] && !b[5]);
            m_copy = b[2];
            m_orig = inv ? !b[15] : b[15];
        end
    endtask

    // driver: one cycle, update reference, push expectation
    task automatic slot(input logic v, input logic a, input logic bs, input logic pe,
                        input logic be, input logic lk, input logic bit_in,
                        input string etag, input string stag);
        exp_item_t it;
        @(negedge clk);
        sf_valid = v; sf_chan_a = a; blk_start = bs; par_err = pe;
        bip_err = be; pll_lock = lk; cs_bit = bit_in;
        @(posedge clk);
        #1;
        if (v) begin
            m_err = pe | be | !lk;
            if (!lk) m_coll = 1'b0;
            else if (a && bs) begin
                m_coll = 1'b1; m_idx = 1; m_buf[0] = bit_in;
            end else if (a && m_coll) begin
                if (m_idx < 16) m_buf[m_idx] = bit_in;
                if (m_idx == 191) begin
                    m_coll = 1'b0;
                    commit(m_buf);
                end else m_idx++;
            end
        end
        it.err = m_err; it.pro = m_pro; it.emph_n = m_emph_n;
        it.copy_ok = m_copy; it.orig = m_orig; it.etag = etag; it.stag = stag;
        q.push_back(it);
    endtask

    // monitor: pop one expectation each cycle and compare at the ports
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_item_t it;
                it = q.pop_front();
                chk(it.etag, "rx_err", rx_err, it.err);
                chk({"R7 ", it.stag}, "pro", pro, it.pro);
                chk({"R8 ", it.stag}, "emph_n", emph_n, it.emph_n);
                chk({"R9 ", it.stag}, "copy_ok", copy_ok, it.copy_ok);
                chk({"R10 ", it.stag}, "orig", orig, it.orig);
            end
        end
    end

    // n channel-A frames, B frames carry inverted bits and injected errors
    task automatic run_block(input logic [15:0] head, input int n_a,
                             input int drop_at, input string stag);
        for (int i = 0; i < n_a; i++) begin
            logic b;
            b = (i < 16) ? head[i] : logic'(i % 3 == 0);
            slot(1, 1, (i == 0), 0, 0, 1, b, "R5", stag);
            if (i == 10)
                slot(1, 0, 0, 1, 0, 1, !b, "R3", stag);
            else if (i == 20)
                slot(1, 0, 1, 0, 1, 1, !b, "R4", stag);
            else if (i == drop_at)
                slot(1, 0, 0, 0, 0, 0, !b, "R5", "R11");
            else
                slot(1, 0, 0, 0, 0, 1, !b, "R5", stag);
            if (i % 64 == 63)
                slot(0, 1, 1, 1, 1, 0, 1, "R2", stag);
        end
    endtask

    initial begin
        rst_n = 0; sf_valid = 0; sf_chan_a = 0; blk_start = 0;
        par_err = 0; bip_err = 0; pll_lock = 0; cs_bit = 0;
        m_err = 1; m_pro = 0; m_emph_n = 1; m_copy = 0; m_orig = 0;
        m_coll = 0; m_idx = 0; m_buf = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "rx_err", rx_err, 1'b1);
        chk("R1", "pro", pro, 1'b0);
        chk("R1", "emph_n", emph_n, 1'b1);
        chk("R1", "copy_ok", copy_ok, 1'b0);
        chk("R1", "orig", orig, 1'b0);
        rst_n = 1;
        // R6: channel-A bits with no start marker never commit
        for (int i = 0; i < 200; i++) slot(1, 1, 0, 0, 0, 1, 1, "R5", "R6");
        // R6 R8 R9 R10: consumer, 50/15, copy allowed, category 0, L=1
        run_block(16'h800C, 192, -1, "R6");
        // R13: category 0x01 inverting, L=1 -> copy; no emphasis, no copy
        run_block(16'h8100, 192, -1, "R13");
        // R13: category 0x04 inverting, L=0 -> original
        run_block(16'h0404, 192, -1, "R13");
        // R13: category 0x09 matches group (x&7)==1, L=0
        run_block(16'h0904, 192, -1, "R13");
        // R11: lock drop mid-block, outputs hold
        run_block(16'h801D, 192, 100, "R11");
        // R5: lock comes back only after a clean sub-frame
        slot(1, 0, 0, 0, 0, 1, 0, "R5", "R11");
        // R8 R9 R10: professional, 50/15
        run_block(16'h000D, 192, -1, "R7");
        // R12: partial block then restart, second block commits
        run_block(16'h0005, 120, -1, "R12");
        run_block(16'h2018, 192, -1, "R12");
        // R8: professional, other emphasis code; R10 consumer ordinary L=0
        run_block(16'h0015, 192, -1, "R8");
        run_block(16'h0228, 192, -1, "R10");
        // R2: idle noise leaves rx_err alone
        for (int i = 0; i < 8; i++) slot(0, 0, 1, 1, 1, 0, 1, "R2", "R6");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule